// File: doc/BRIEF.md
# Receive frame alignment monitor

This block sits in a serial converter link's receive path, directly after the 8b/10b decoder. It counts octets into frames of F octets and frames into multiframes of K frames. Alongside each octet it reports whether that octet starts a frame and whether it starts a multiframe. The transmitter replaces some frame-end octets with two alignment control characters: the frame marker (control code 0xFC) and the multiframe marker (control code 0x7C). The monitor puts the original data octet back in their place and checks that each marker falls on the last octet of a frame.

The replacement value depends on the scrambling mode. With scrambling off, the monitor reuses the restored octet that ended the previous frame. With scrambling on, each marker stands for a fixed value.

A marker that arrives away from the frame end is a misalignment. One misplaced marker raises a flag and its position is kept as a candidate. A second marker in a row at that same position moves the frame boundary onto it and emits a one-cycle realignment event.

Top module: `frame_align_mon`

## Requirements
- R1: After reset, every output is 0 until the first accepted octet arrives. That first octet is marked as both frame start and multiframe start.
- R2: Frame start is set on every cfg_f-th accepted octet, counting the first one after reset. Multiframe start is set on the first octet of every cfg_k-th frame.
- R3: With scr_en=1, a control octet 0xFC is output as data 0xFC and a control octet 0x7C is output as data 0x7C, both with out_ctrl=0. Any other control octet passes through unchanged with out_ctrl=1.
- R4: With scr_en=0, a control octet 0xFC or 0x7C is output with out_ctrl=0, carrying the restored octet that ended the previous frame (0x00 before any frame has ended).
- R5: The stored frame-end octet is the restored value. Markers in consecutive frames therefore all carry the last true data octet.
- R6: A marker whose position is not the last octet of a frame sets out_misalign for that octet. If it is the first such marker, out_realign stays 0 and the framing is unchanged.
- R7: Two consecutive markers at the same non-final position set out_realign (and out_misalign) on the second one. The next accepted octet is a frame start.
- R8: A misplaced marker at a different position from the stored candidate replaces that candidate without realigning. A later marker at the new position realigns.
- R9: A marker at the correct frame-end position clears the candidate. A following misplaced marker is then treated as a first occurrence.
- R10: A realignment caused by 0x7C makes the next octet a multiframe start. A realignment caused by 0xFC advances the frame count within the multiframe by one.
- R11: While in_valid=0, no counter or stored state changes, and out_valid, out_frame_start, out_mf_start, out_realign and out_misalign are 0 on the next cycle.
- R12: Each accepted octet appears on the outputs exactly one clock cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded octet present this cycle |
| in_octet | input | 8 | Decoded octet |
| in_ctrl | input | 1 | Octet is a control character |
| scr_en | input | 1 | Scrambling is enabled on the link |
| cfg_f | input | $clog2(MAX_F+1) | Octets per frame, 1..MAX_F, held during operation |
| cfg_k | input | $clog2(MAX_K+1) | Frames per multiframe, 1..MAX_K, held during operation |
| out_valid | output | 1 | Restored octet present |
| out_octet | output | 8 | Restored octet |
| out_ctrl | output | 1 | Restored octet is still a control character |
| out_frame_start | output | 1 | Octet is the first of a frame |
| out_mf_start | output | 1 | Octet is the first of a multiframe |
| out_realign | output | 1 | Frame boundary was moved at this octet |
| out_misalign | output | 1 | Marker found away from the frame end |

## Verification
The bench builds the block with MAX_F=8 and MAX_K=4 and drives several settings at run time.
- F=4, K=2 reaches every marker position inside a frame for the directed realignment cases.
- F=1, K=3 makes every octet a frame end, so no marker can ever be misplaced.
- F=5, K=3 with random markers and gaps reaches multiframe wrap, realignment and candidate replacement together, in both scrambling modes.

// File: rtl/fam_pkg.sv
package fam_pkg;
  localparam logic [7:0] MARK_FRAME = 8'hFC;
  localparam logic [7:0] MARK_MULTI = 8'h7C;

  function automatic logic is_marker(input logic [7:0] oct, input logic ctl);
    return ctl && (oct == MARK_FRAME || oct == MARK_MULTI);
  endfunction

  // Value a marker stands for, given the scrambling mode
  function automatic logic [7:0] marker_value(input logic [7:0] oct, input logic scr,
                                              input logic [7:0] prev_end);
    return scr ? oct : prev_end;
  endfunction
endpackage

// File: rtl/fam_pos_ctr.sv
module fam_pos_ctr #(
  parameter int FCW = 4,
  parameter int KCW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           force_end,
  input  logic           force_mf,
  input  logic [FCW-1:0] cfg_f,
  input  logic [KCW-1:0] cfg_k,
  output logic [FCW-1:0] oct_pos,
  output logic [KCW-1:0] frm_pos,
  output logic           at_fend
);
  logic frame_done;
  assign at_fend    = (oct_pos == cfg_f - FCW'(1));
  assign frame_done = at_fend || force_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oct_pos <= '0;
      frm_pos <= '0;
    end else if (adv) begin
      if (frame_done) begin
        oct_pos <= '0;
        if (force_mf || frm_pos == cfg_k - KCW'(1)) frm_pos <= '0;
        else                                       frm_pos <= frm_pos + KCW'(1);
      end else begin
        oct_pos <= oct_pos + FCW'(1);
      end
    end
  end
endmodule

// File: rtl/fam_cand_trk.sv
module fam_cand_trk #(
  parameter int FCW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           marker,
  input  logic           at_fend,
  input  logic [FCW-1:0] oct_pos,
  output logic           misplaced,
  output logic           realign_evt
);
  logic           cand_v;
  logic [FCW-1:0] cand_p;

  assign misplaced   = adv && marker && !at_fend;
  assign realign_evt = misplaced && cand_v && (cand_p == oct_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_v <= 1'b0;
      cand_p <= '0;
    end else if (adv && marker) begin
      if (at_fend || realign_evt) begin
        cand_v <= 1'b0;
      end else begin
        cand_v <= 1'b1;
        cand_p <= oct_pos;
      end
    end
  end
endmodule

// File: rtl/fam_restore.sv
module fam_restore (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       frame_end,
  input  logic [7:0] oct,
  input  logic       ctl,
  input  logic       scr_en,
  input  logic       marker,
  output logic [7:0] r_oct,
  output logic       r_ctl
);
  import fam_pkg::*;
  logic [7:0] prev_end;

  assign r_oct = marker ? marker_value(oct, scr_en, prev_end) : oct;
  assign r_ctl = marker ? 1'b0 : ctl;

  always_ff @(posedge clk) begin
    if (!rst_n)                 prev_end <= 8'h00;
    else if (adv && frame_end)  prev_end <= r_oct;
  end
endmodule

// File: rtl/frame_align_mon.sv
module frame_align_mon #(
  parameter int MAX_F = 16,
  parameter int MAX_K = 32,
  localparam int FCW = $clog2(MAX_F + 1),
  localparam int KCW = $clog2(MAX_K + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [7:0]     in_octet,
  input  logic           in_ctrl,
  input  logic           scr_en,
  input  logic [FCW-1:0] cfg_f,
  input  logic [KCW-1:0] cfg_k,
  output logic           out_valid,
  output logic [7:0]     out_octet,
  output logic           out_ctrl,
  output logic           out_frame_start,
  output logic           out_mf_start,
  output logic           out_realign,
  output logic           out_misalign
);
  import fam_pkg::*;

  logic [FCW-1:0] oct_pos;
  logic [KCW-1:0] frm_pos;
  logic           at_fend, marker, misplaced, realign_evt;
  logic [7:0]     r_oct;
  logic           r_ctl;

  assign marker = is_marker(in_octet, in_ctrl);

  fam_pos_ctr #(.FCW(FCW), .KCW(KCW)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(in_valid),
    .force_end(realign_evt),
    .force_mf(realign_evt && in_octet == MARK_MULTI),
    .cfg_f(cfg_f), .cfg_k(cfg_k),
    .oct_pos(oct_pos), .frm_pos(frm_pos), .at_fend(at_fend)
  );

  fam_cand_trk #(.FCW(FCW)) u_cand (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .marker(marker),
    .at_fend(at_fend), .oct_pos(oct_pos),
    .misplaced(misplaced), .realign_evt(realign_evt)
  );

  fam_restore u_rest (
    .clk(clk), .rst_n(rst_n), .adv(in_valid),
    .frame_end(at_fend || realign_evt),
    .oct(in_octet), .ctl(in_ctrl), .scr_en(scr_en), .marker(marker),
    .r_oct(r_oct), .r_ctl(r_ctl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_octet       <= 8'h00;
      out_ctrl        <= 1'b0;
      out_frame_start <= 1'b0;
      out_mf_start    <= 1'b0;
      out_realign     <= 1'b0;
      out_misalign    <= 1'b0;
    end else if (in_valid) begin
      out_valid       <= 1'b1;
      out_octet       <= r_oct;
      out_ctrl        <= r_ctl;
      out_frame_start <= (oct_pos == '0);
      out_mf_start    <= (oct_pos == '0) && (frm_pos == '0);
      out_realign     <= realign_evt;
      out_misalign    <= misplaced;
    end else begin
      out_valid       <= 1'b0;
      out_ctrl        <= 1'b0;
      out_frame_start <= 1'b0;
      out_mf_start    <= 1'b0;
      out_realign     <= 1'b0;
      out_misalign    <= 1'b0;
    end
  end
endmodule

// File: rtl/fam_checker.sv
module fam_checker #(
  parameter int FCW = 4,
  parameter int KCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [7:0]     in_octet,
  input logic           in_ctrl,
  input logic           scr_en,
  input logic [FCW-1:0] cfg_f,
  input logic [KCW-1:0] cfg_k,
  input logic           out_valid,
  input logic [7:0]     out_octet,
  input logic           out_ctrl,
  input logic           out_frame_start,
  input logic           out_mf_start,
  input logic           out_realign,
  input logic           out_misalign,
  input logic [FCW-1:0] oct_pos,
  input logic [KCW-1:0] frm_pos,
  input logic           realign_evt
);
  assert_pos_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (oct_pos < cfg_f) && (frm_pos < cfg_k));

  assert_mf_implies_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_mf_start |-> out_frame_start);

  assert_scr_frame_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scr_en && in_ctrl && in_octet == 8'hFC) |=> (out_octet == 8'hFC && !out_ctrl));

  assert_realign_is_misplaced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_realign |-> out_misalign);

  assert_realign_restarts_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    realign_evt |=> (oct_pos == '0));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_realign && !out_misalign && !out_frame_start));

  assert_one_cycle_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
endmodule

bind frame_align_mon fam_checker #(.FCW(FCW), .KCW(KCW)) u_fam_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_octet(in_octet),
  .in_ctrl(in_ctrl), .scr_en(scr_en), .cfg_f(cfg_f), .cfg_k(cfg_k),
  .out_valid(out_valid), .out_octet(out_octet), .out_ctrl(out_ctrl),
  .out_frame_start(out_frame_start), .out_mf_start(out_mf_start),
  .out_realign(out_realign), .out_misalign(out_misalign),
  .oct_pos(oct_pos), .frm_pos(frm_pos), .realign_evt(realign_evt)
);

// File: tb/frame_align_mon_bench.sv
module frame_align_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_F = 8;
  localparam int MAX_K = 4;
  localparam int FCW = $clog2(MAX_F + 1);
  localparam int KCW = $clog2(MAX_K + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [7:0]     in_octet = 8'h00;
  logic           in_ctrl = 1'b0;
  logic           scr_en = 1'b0;
  logic [FCW-1:0] cfg_f = FCW'(4);
  logic [KCW-1:0] cfg_k = KCW'(2);
  logic           out_valid, out_ctrl, out_frame_start, out_mf_start, out_realign, out_misalign;
  logic [7:0]     out_octet;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_align_mon #(.MAX_F(MAX_F), .MAX_K(MAX_K)) u_frame_align_mon (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_octet(in_octet),
    .in_ctrl(in_ctrl), .scr_en(scr_en), .cfg_f(cfg_f), .cfg_k(cfg_k),
    .out_valid(out_valid), .out_octet(out_octet), .out_ctrl(out_ctrl),
    .out_frame_start(out_frame_start), .out_mf_start(out_mf_start),
    .out_realign(out_realign), .out_misalign(out_misalign)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state restated from the requirements
  int       m_pos, m_frm, m_f, m_k;
  bit       m_cv;
  int       m_cp;
  bit [7:0] m_prev;

  function automatic bit ref_marker(bit [7:0] o, bit c);
    return c && (o == 8'hFC || o == 8'h7C);
  endfunction

  task automatic compare(string tag, bit [13:0] act, bit [13:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (v,octet,ctrl,fs,mfs,re,mis)", tag, act, exp);
    end
  endtask

  task automatic do_reset(int f, int k, bit scr);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; cfg_f = FCW'(f); cfg_k = KCW'(k); scr_en = scr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_pos = 0; m_frm = 0; m_f = f; m_k = k; m_cv = 0; m_cp = 0; m_prev = 8'h00;
    #1;
    // R1: all outputs cleared by reset
    compare("R1 reset", {out_valid, out_octet, out_ctrl, out_frame_start, out_mf_start,
                         out_realign, out_misalign}, 14'h0);
  endtask

  task automatic send(bit v, bit [7:0] o, bit c, string tag);
    bit       fs, mfs, hit, fend, mis, re, rc;
    bit [7:0] ro;
    bit [13:0] exp, act;
    @(negedge clk);
    in_valid = v; in_octet = o; in_ctrl = c;
    @(posedge clk);
    #1;
    if (!v) begin
      exp = 14'h0;
    end else begin
      fs   = (m_pos == 0);
      mfs  = fs && (m_frm == 0);
      hit  = ref_marker(o, c);
      fend = (m_pos == m_f - 1);
      mis  = hit && !fend;
      re   = mis && m_cv && (m_cp == m_pos);
      ro   = hit ? (scr_en ? o : m_prev) : o;
      rc   = hit ? 1'b0 : c;
      if (hit) begin
        if (fend || re) m_cv = 0;
        else begin m_cv = 1; m_cp = m_pos; end
      end
      if (fend || re) begin
        m_prev = ro;
        m_pos = 0;
        if (re && o == 8'h7C) m_frm = 0;
        else m_frm = (m_frm == m_k - 1) ? 0 : m_frm + 1;
      end else begin
        m_pos++;
      end
      exp = {1'b1, ro, rc, fs, mfs, re, mis};
    end
    act = {out_valid, out_octet, out_ctrl, out_frame_start, out_mf_start, out_realign, out_misalign};
    if (!v) act[12:5] = 8'h00;
    compare(tag, act, exp);
  endtask

  task automatic fill(int n, string tag);
    for (int i = 0; i < n; i++) send(1, 8'($urandom_range(0, 255)), 0, tag);
  endtask

  task automatic random_run(int n, int f, int k, bit scr);
    do_reset(f, k, scr);
    for (int i = 0; i < n; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 8)       send(0, 8'h00, 0, "R11 random gap");
      else if (r < 20) send(1, 8'hFC, 1, "R2 R6 random frame marker");
      else if (r < 28) send(1, 8'h7C, 1, "R10 random multi marker");
      else if (r < 31) send(1, 8'hBC, 1, "R3 random other control");
      else             send(1, 8'($urandom_range(0, 255)), 0, "R2 random data");
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R4, R5: unscrambled restoration
    do_reset(4, 2, 0);
    send(1, 8'hFC, 1, "R4 marker before any frame end");
    do_reset(4, 2, 0);
    send(1, 8'h11, 0, "R12 first octet one cycle later");
    send(1, 8'h22, 0, "R2"); send(1, 8'h33, 0, "R2"); send(1, 8'h44, 0, "R2");
    fill(3, "R2 second frame");
    send(1, 8'hFC, 1, "R4 frame marker restored from previous end");
    fill(3, "R2 multiframe wrap");
    send(1, 8'h7C, 1, "R5 repeated replacement carries value");
    // R6 then R7 realign with frame marker
    send(0, 8'h00, 0, "R11 idle");
    send(1, 8'h01, 0, "R2");
    send(1, 8'hFC, 1, "R6 single misplaced marker");
    fill(2, "R6 framing unchanged");
    send(1, 8'h05, 0, "R2");
    send(1, 8'hFC, 1, "R7 second misplaced marker realigns");
    send(1, 8'h09, 0, "R7 next octet starts frame");
    // R10 realign with multiframe marker
    do_reset(4, 2, 0);
    fill(2, "R2"); send(1, 8'h7C, 1, "R6"); send(1, 8'h0A, 0, "R2");
    fill(2, "R2"); send(1, 8'h7C, 1, "R10 multi marker realigns");
    send(1, 8'h0B, 0, "R10 next octet starts multiframe");
    // R8 candidate replacement
    do_reset(4, 2, 0);
    fill(1, "R8"); send(1, 8'hFC, 1, "R8 first candidate");
    fill(2, "R8"); fill(2, "R8");
    send(1, 8'hFC, 1, "R8 new position no realign");
    fill(1, "R8"); fill(2, "R8");
    send(1, 8'hFC, 1, "R8 realign at replaced candidate");
    // R9 aligned marker clears candidate
    do_reset(4, 2, 0);
    fill(1, "R9"); send(1, 8'hFC, 1, "R9 candidate");
    fill(2, "R9"); fill(3, "R9");
    send(1, 8'hFC, 1, "R9 aligned marker");
    fill(1, "R9");
    send(1, 8'hFC, 1, "R9 misplaced after clear no realign");
    // R3 scrambled mode
    do_reset(4, 2, 1);
    fill(3, "R3"); send(1, 8'hFC, 1, "R3 frame marker fixed value");
    fill(3, "R3"); send(1, 8'h7C, 1, "R3 multi marker fixed value");
    send(1, 8'hBC, 1, "R3 other control passes");
    // F=1: every octet ends a frame
    do_reset(1, 3, 0);
    for (int i = 0; i < 7; i++) send(1, (i % 2) ? 8'hFC : 8'h3C, (i % 2) == 1, "R2 single-octet frames");
    random_run(3000, 5, 3, 0);
    random_run(3000, 5, 3, 1);
    random_run(1500, 8, 4, 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule